// File: doc/BRIEF.md
# Scanline start address generator

This block produces the memory address of the first byte of each visible scanline for a raster display controller whose start address and line pitch have been widened beyond the classic 16-bit and 8-bit fields. A 20-bit frame start address is assembled from the two classic start bytes plus extension bits held in two further control registers. A 9-bit offset value, whose top bit is one of those extension bits, sets the line pitch.

At the start of every frame the block samples the control registers once. It computes the address of the first displayed line by folding in the vertical fine scroll (preset row count times pitch) and the horizontal byte pan. On every line-end strobe it steps the address forward by the captured pitch. All address arithmetic wraps within the 1 MiB address space.

The fetch engine downstream reads `line_addr` as the base of the line it is about to display.

Top module: `scan_start_gen`

## Requirements
- R1: While `rst_n` is low, `line_addr` is 0, and the captured pitch is 0.
- R2: The frame start address has these fields. Bits 15:8 are `start_hi`, bits 7:0 are `start_lo`, bit 16 is `ext_disp[0]`, bits 18:17 are `ext_disp[3:2]`, and bit 19 is `overlay[7]`.
- R3: The line pitch in bytes is twice the 9-bit offset value. The offset value is `{ext_disp[4], offset[7:0]}`.
- R4: `line_addr` changes in the cycle after a `frame_start` pulse. Its new value is the start address, plus `row_pan[4:0]` times the pitch, plus `row_pan[6:5]`.
- R5: In the cycle after a `line_end` pulse without `frame_start`, `line_addr` equals its previous value plus the pitch captured at the last frame start.
- R6: With neither strobe high, `line_addr` holds its value.
- R7: When `frame_start` and `line_end` are high in the same cycle, the frame reload wins and no step is added.
- R8: Register inputs are sampled only at `frame_start`. A change to `offset` or `ext_disp[4]` between frame starts does not alter the step size.
- R9: All address sums wrap modulo 2^20.
- R10: These bits have no effect on `line_addr`: `ext_disp[1]`, `ext_disp[7:5]`, `overlay[6:0]` and `row_pan[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse: reload for a new frame |
| line_end | input | 1 | One-cycle pulse: advance to the next line |
| start_lo | input | 8 | Start address bits 7:0 |
| start_hi | input | 8 | Start address bits 15:8 |
| ext_disp | input | 8 | Extended display register (address bits 16..18, offset bit 8) |
| overlay | input | 8 | Overlay register (bit 7 is address bit 19) |
| offset | input | 8 | Offset register, low 8 bits of the pitch count |
| row_pan | input | 8 | Preset row count [4:0] and byte pan [6:5] |
| line_addr | output | 20 | Start address of the current scanline |

## Verification
The assertions assume that both strobes are known, synchronous signals once reset is released. They also assume that the reload value `first_addr` is valid in the very cycle `frame_start` is high, since they compare the next `line_addr` against it. The stimulus changes every input only on the falling clock edge and holds it for a full period. Register fields may change in any cycle, including between frames, which exercises the rule that only the sample taken at frame start matters.

// File: rtl/scan_start_pkg.sv
package scan_start_pkg;

  localparam int ADDR_W  = 20;
  localparam int OFS_W   = 9;
  localparam int PITCH_W = OFS_W + 1;
  localparam int ROW_W   = 5;
  localparam int PAN_W   = 2;
  localparam int PROD_W  = PITCH_W + ROW_W;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [PITCH_W-1:0] pitch_t;

  // Assemble the 20-bit frame start address from the scattered fields.
  function automatic addr_t join_start(input logic [7:0] lo, input logic [7:0] hi,
                                       input logic [3:0] ext_lo, input logic ovl_msb);
    addr_t a;
    a = {ovl_msb, ext_lo[3:2], ext_lo[0], hi, lo};
    return a;
  endfunction

  // Pitch in bytes: the 9-bit offset count times two.
  function automatic pitch_t pitch_bytes(input logic [7:0] ofs, input logic ofs_msb);
    return {ofs_msb, ofs, 1'b0};
  endfunction

  // Modular sum of the start address and a narrower term.
  function automatic addr_t add_wrap(input addr_t a, input addr_t b);
    return a + b;
  endfunction

endpackage

// File: rtl/scan_start_assemble.sv
module scan_start_assemble
  import scan_start_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PITCH_W
) (
  input  logic [7:0]    start_lo,
  input  logic [7:0]    start_hi,
  input  logic [7:0]    ext_disp,
  input  logic [7:0]    overlay,
  input  logic [7:0]    offset,
  output logic [AW-1:0] start_addr,
  output logic [PW-1:0] pitch
);

  // Bits with no meaning for this block (R10).
  logic unused_fields;
  assign unused_fields = ^{ext_disp[7:5], ext_disp[1], overlay[6:0]};

  assign start_addr = AW'(join_start(start_lo, start_hi, ext_disp[3:0], overlay[7]));
  assign pitch      = PW'(pitch_bytes(offset, ext_disp[4]));

endmodule

// File: rtl/scan_first_line.sv
module scan_first_line
  import scan_start_pkg::*;
#(
  parameter int AW        = ADDR_W,
  parameter int PW        = PITCH_W,
  parameter int RW        = ROW_W,
  parameter int NW        = PAN_W,
  parameter bit SHIFT_ADD = 1'b1
) (
  input  logic [AW-1:0] start_addr,
  input  logic [PW-1:0] pitch,
  input  logic [RW-1:0] row_cnt,
  input  logic [NW-1:0] pan,
  output logic [AW-1:0] first_addr
);

  localparam int PRW = PW + RW;

  logic [PRW-1:0] row_off;

  generate
    if (SHIFT_ADD) begin : g_shift_add
      // One partial product per row-count bit, summed in a chain.
      logic [PRW-1:0] acc [RW+1];
      assign acc[0] = '0;
      for (genvar i = 0; i < RW; i++) begin : g_pp
        logic [PRW-1:0] part;
        assign part       = row_cnt[i] ? (PRW'(pitch) << i) : '0;
        assign acc[i+1]   = acc[i] + part;
      end
      assign row_off = acc[RW];
    end else begin : g_mult
      assign row_off = PRW'(pitch) * PRW'(row_cnt);
    end
  endgenerate

  assign first_addr = start_addr + AW'(row_off) + AW'(pan);

endmodule

// File: rtl/scan_line_stepper.sv
module scan_line_stepper
  import scan_start_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PITCH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          line_end,
  input  logic [AW-1:0] first_addr,
  input  logic [PW-1:0] pitch_in,
  output logic [AW-1:0] addr_q,
  output logic [PW-1:0] pitch_q,
  output logic          step_evt
);

  assign step_evt = line_end & ~frame_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      pitch_q <= '0;
    end else if (frame_start) begin
      addr_q  <= first_addr;
      pitch_q <= pitch_in;
    end else if (step_evt) begin
      addr_q  <= addr_q + AW'(pitch_q);
    end
  end

endmodule

// File: rtl/scan_start_gen.sv
module scan_start_gen
  import scan_start_pkg::*;
#(
  parameter int AW        = ADDR_W,
  parameter int PW        = PITCH_W,
  parameter int RW        = ROW_W,
  parameter int NW        = PAN_W,
  parameter bit SHIFT_ADD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          line_end,
  input  logic [7:0]    start_lo,
  input  logic [7:0]    start_hi,
  input  logic [7:0]    ext_disp,
  input  logic [7:0]    overlay,
  input  logic [7:0]    offset,
  input  logic [7:0]    row_pan,
  output logic [AW-1:0] line_addr
);

  logic [AW-1:0] start_addr;
  logic [PW-1:0] pitch;
  logic [AW-1:0] first_addr;
  logic [PW-1:0] pitch_q;
  logic          step_evt;

  // row_pan[7] carries nothing here (R10).
  logic unused_row;
  assign unused_row = row_pan[7];

  scan_start_assemble #(.AW(AW), .PW(PW)) asm_i (
    .start_lo   (start_lo),
    .start_hi   (start_hi),
    .ext_disp   (ext_disp),
    .overlay    (overlay),
    .offset     (offset),
    .start_addr (start_addr),
    .pitch      (pitch)
  );

  scan_first_line #(.AW(AW), .PW(PW), .RW(RW), .NW(NW), .SHIFT_ADD(SHIFT_ADD)) first_i (
    .start_addr (start_addr),
    .pitch      (pitch),
    .row_cnt    (row_pan[RW-1:0]),
    .pan        (row_pan[RW+NW-1:RW]),
    .first_addr (first_addr)
  );

  scan_line_stepper #(.AW(AW), .PW(PW)) step_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_end    (line_end),
    .first_addr  (first_addr),
    .pitch_in    (pitch),
    .addr_q      (line_addr),
    .pitch_q     (pitch_q),
    .step_evt    (step_evt)
  );

endmodule

// File: rtl/scan_start_gen_chk.sv
module scan_start_gen_chk #(
  parameter int AW = 20,
  parameter int PW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          line_end,
  input logic [AW-1:0] line_addr,
  input logic [AW-1:0] first_addr,
  input logic [PW-1:0] pitch_q,
  input logic          step_evt
);

  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> line_addr == $past(first_addr)); // R4

  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && line_end) |=> line_addr == $past(first_addr)); // R7

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> line_addr == AW'($past(line_addr) + AW'($past(pitch_q)))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !line_end) |=> $stable(line_addr)); // R6

  AST_PITCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(pitch_q)); // R8

endmodule

bind scan_start_gen scan_start_gen_chk #(.AW(AW), .PW(PW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .line_end    (line_end),
  .line_addr   (line_addr),
  .first_addr  (first_addr),
  .pitch_q     (pitch_q),
  .step_evt    (step_evt)
);

// File: tb/scan_start_gen_tb_top.sv
`timescale 1ns/1ps
module scan_start_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        line_end = 1'b0;
  logic [7:0]  start_lo = 8'h0, start_hi = 8'h0, ext_disp = 8'h0;
  logic [7:0]  overlay = 8'h0, offset = 8'h0, row_pan = 8'h0;
  logic [19:0] line_addr;

  always #2.5 clk = ~clk;

  scan_start_gen dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_end(line_end),
    .start_lo(start_lo), .start_hi(start_hi), .ext_disp(ext_disp),
    .overlay(overlay), .offset(offset), .row_pan(row_pan), .line_addr(line_addr)
  );

  typedef struct { int exp; string tag; } item_t;
  item_t sbq[$];

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  int  m_addr = 0, m_pitch = 0;
  int  s_lo = 0, s_hi = 0, s_ext = 0, s_ovl = 0, s_ofs = 0, s_row = 0;

  localparam int MOD = 1 << 20;

  function automatic int f_start();
    return s_lo + s_hi * 256 + (s_ext & 1) * 65536 + ((s_ext >> 2) & 3) * 131072
           + ((s_ovl >> 7) & 1) * 524288;
  endfunction

  function automatic int f_pitch();
    return (s_ofs + ((s_ext >> 4) & 1) * 256) * 2;
  endfunction

  function automatic int f_first();
    return (f_start() + (s_row & 31) * f_pitch() + ((s_row >> 5) & 3)) % MOD;
  endfunction

  // Driver: apply staged values at the falling edge, push the expected result.
  task automatic drive(input bit fs, input bit le, input string tag);
    item_t it;
    @(negedge clk);
    start_lo = 8'(s_lo); start_hi = 8'(s_hi); ext_disp = 8'(s_ext);
    overlay = 8'(s_ovl); offset = 8'(s_ofs); row_pan = 8'(s_row);
    frame_start = fs; line_end = le;
    if (fs) begin
      m_pitch = f_pitch();
      m_addr  = f_first();
    end else if (le) begin
      m_addr = (m_addr + m_pitch) % MOD;
    end
    it.exp = m_addr; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic stage(input int lo, input int hi, input int ext, input int ovl,
                       input int ofs, input int row);
    s_lo = lo; s_hi = hi; s_ext = ext; s_ovl = ovl; s_ofs = ofs; s_row = row;
  endtask

  // Monitor: compare one item per clock after the edge has settled.
  always @(posedge clk) begin
    #1;
    if (rst_n && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      n_chk++;
      if (int'(line_addr) != it.exp) begin
        n_fail++;
        $display("FAIL %s actual %05h expected %05h", it.tag, line_addr, it.exp[19:0]);
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset holds the address at zero even with strobes active
    stage(8'hAB, 8'hCD, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    @(negedge clk);
    start_lo = 8'hAB; frame_start = 1'b1; line_end = 1'b1;
    repeat (4) @(negedge clk);
    n_chk++;
    if (line_addr !== 20'h0) begin
      n_fail++;
      $display("FAIL R1 actual %05h expected 00000", line_addr);
    end
    frame_start = 1'b0; line_end = 1'b0;
    rst_n = 1'b1;

    // R1: the captured pitch is zero after reset, so a step adds nothing
    m_addr = 0; m_pitch = 0;
    drive(0, 1, "R1 step with reset pitch");

    // R2 R4: plain 16-bit start, no scroll
    stage(8'h34, 8'h12, 0, 0, 40, 0);
    drive(1, 0, "R2 R4 plain start");
    drive(0, 1, "R5 step 1");
    drive(0, 1, "R5 step 2");
    drive(0, 1, "R5 step 3");
    drive(0, 0, "R6 idle 1");
    drive(0, 0, "R6 idle 2");

    // R2: every extension bit set, address FFFFF, then R9 wrap
    stage(8'hFF, 8'hFF, 8'h0D, 8'h80, 1, 0);
    drive(1, 0, "R2 extension bits");
    drive(0, 1, "R9 wrap on step");

    // R2: each extension bit alone
    stage(0, 0, 8'h01, 0, 0, 0); drive(1, 0, "R2 bit16");
    stage(0, 0, 8'h04, 0, 0, 0); drive(1, 0, "R2 bit17");
    stage(0, 0, 8'h08, 0, 0, 0); drive(1, 0, "R2 bit18");
    stage(0, 0, 0, 8'h80, 0, 0); drive(1, 0, "R2 bit19");

    // R3: ninth offset bit, pitch 0x300
    stage(0, 0, 8'h10, 0, 8'h80, 0);
    drive(1, 0, "R3 load");
    drive(0, 1, "R3 pitch with bit8");
    drive(0, 1, "R3 pitch second line");

    // R4: row count 3, pan 2
    stage(8'h10, 0, 0, 0, 20, 8'h43);
    drive(1, 0, "R4 row scan and pan");
    stage(8'h10, 0, 0, 0, 20, 8'h7F);
    drive(1, 0, "R4 max row and pan");

    // R9: first-line sum crossing the top
    stage(8'hF0, 8'hFF, 8'h1D, 8'h80, 8'hFF, 8'h7F);
    drive(1, 0, "R9 first line wrap");
    drive(0, 1, "R9 step wrap");

    // R10: ignored bits
    stage(8'h55, 8'h22, 8'hE2, 8'h7F, 10, 8'h80);
    drive(1, 0, "R10 ignored bits");
    drive(0, 1, "R10 step with ignored bits");

    // R8: register changes between frame starts do not alter the step
    stage(0, 1, 0, 0, 10, 0);
    drive(1, 0, "R8 load");
    stage(8'h77, 8'h66, 8'h1D, 8'h80, 200, 8'h25);
    drive(0, 1, "R8 step uses captured pitch");
    drive(0, 0, "R8 idle after change");
    drive(0, 1, "R8 second step");

    // R7: both strobes together
    stage(8'h00, 8'h40, 0, 0, 5, 1);
    drive(1, 1, "R7 reload wins");
    drive(0, 1, "R7 step after reload");

    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 3) == 0)
        stage(int'($urandom % 256), int'($urandom % 256), int'($urandom % 256),
              int'($urandom % 256), int'($urandom % 256), int'($urandom % 256));
      drive(($urandom % 10) == 0, ($urandom % 2) == 1, "R5 R6 R7 R8 mixed");
    end

    drive(0, 0, "R6 final idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule